// File: doc/BRIEF.md
# CAN Controller Freeze-Mode Sequencer

This block decides when a CAN controller's configuration logic may be treated as frozen. Software sets two control bits, a halt bit and a freeze-enable bit. Only the pair together forms a freeze request. The sequencer does not grant that request at once. It first waits for the transmit and receive engines to go idle and for the low-power condition to be gone. It then stops the bit-time prescaler. One cycle later it reports the freeze acknowledge. When software drops the request, the prescaler restarts and the acknowledge falls together, one clock after the request goes away.

The block also tracks a module-disable input and combines it with the frozen state into a single not-ready status. It produces a start permission that the protocol engines consult before they open a new frame. It holds the error-counter register. The protocol engine can load that register at any time, but the CPU may load it only while the acknowledge is high. Both control bits reset to 1, so the controller leaves hard reset already frozen and waits there for software to finish its configuration.

Top module: `can_frz_seq`

## Requirements
- R1: After reset, `presc_stop`, `frz_ack` and `not_rdy` are 1, `xfer_start_ok` is 0 and `ecr_value` is 0. Both control bits reset to 1, so the block starts frozen.
- R2: A freeze is requested only while both stored bits are 1. With halt at 1 and freeze-enable at 0, `presc_stop` and `frz_ack` stay 0 and `not_rdy` stays 0.
- R3: Consider a clock edge at which the request is present, `tx_busy` and `rx_busy` are 0 and `lp_mode` is 0. `presc_stop` rises at that edge and `frz_ack` rises at the following edge, so the acknowledge never comes before the prescaler stop.
- R4: While `tx_busy` or `rx_busy` is 1, a pending request raises neither `presc_stop` nor `frz_ack`.
- R5: While `lp_mode` is 1, freeze entry is deferred. Once `lp_mode` returns to 0, entry proceeds as in R3.
- R6: A control write that clears the request is captured at edge k. At edge k+1, `presc_stop` and `frz_ack` both return to 0. `frz_ack` never falls while `presc_stop` stays 1.
- R7: `not_rdy` is 1 whenever the block is frozen (`frz_ack`=1) or disabled. Disable begins at the first edge where `mdis`=1 and both engines are idle. It ends at the edge after `mdis` returns to 0.
- R8: `xfer_start_ok` is 1 only when the prescaler runs, the stored halt bit is 0, the block is not disabled and `lp_mode` is 0.
- R9: A CPU write (`ecr_wr`) loads `ecr_wdata` into `ecr_value` at the edge only if `frz_ack` is 1 in that cycle. Otherwise the write is ignored and `ecr_value` holds its value.
- R10: An engine update (`eng_upd`) loads `eng_data` into `ecr_value` at the edge whenever no accepted CPU write occurs in the same cycle.
- R11: If the request is withdrawn before entry completes, the block stays running. `frz_ack` never rises and `xfer_start_ok` returns to 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| ctl_wr | input | 1 | Strobe that stores both control bits |
| ctl_halt | input | 1 | Halt bit value to store |
| ctl_frz_en | input | 1 | Freeze-enable bit value to store |
| mdis | input | 1 | Module disable request |
| lp_mode | input | 1 | Low-power mode indication |
| tx_busy | input | 1 | Transmit engine has a frame in progress |
| rx_busy | input | 1 | Receive engine has a frame in progress |
| ecr_wr | input | 1 | CPU write strobe for the error-counter register |
| ecr_wdata | input | ECR_W | CPU write data |
| eng_upd | input | 1 | Protocol engine counter update strobe |
| eng_data | input | ECR_W | Protocol engine counter value |
| presc_stop | output | 1 | Stops the bit-time prescaler |
| frz_ack | output | 1 | Freeze acknowledge status |
| not_rdy | output | 1 | Frozen or disabled status |
| xfer_start_ok | output | 1 | Engines may start a new frame |
| ecr_value | output | ECR_W | Current error-counter register contents |

## Verification
The hardest situations to create are the deferred entries: a request that is pending while an engine is busy or while low power is active, and a request that is withdrawn before the engines go idle. The stimulus raises `tx_busy` and `rx_busy` or `lp_mode` before it writes the halt bit, holds them for several cycles to show that nothing moves, and then releases them. It then samples the one-cycle gap between the prescaler stop and the acknowledge. In the withdrawn case, the halt bit is cleared while `tx_busy` is still high. The bench then confirms that no acknowledge ever appears after the engine goes idle.

// File: rtl/frz_pkg.sv
package frz_pkg;

  typedef enum logic [1:0] {
    FS_RUN    = 2'd0,
    FS_STOP   = 2'd1,
    FS_FROZEN = 2'd2
  } frz_state_e;

endpackage

// File: rtl/frz_ctl_bits.sv
module frz_ctl_bits #(
  parameter logic HALT_RST = 1'b1,
  parameter logic FEN_RST  = 1'b1
) (
  input  logic clk,
  input  logic rst_n,
  input  logic wr,
  input  logic halt_d,
  input  logic fen_d,
  output logic halt_q,
  output logic fen_q,
  output logic frz_req
);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      halt_q <= HALT_RST;
      fen_q  <= FEN_RST;
    end else if (wr) begin
      halt_q <= halt_d;
      fen_q  <= fen_d;
    end
  end

  // freeze is only requested when both bits agree
  assign frz_req = halt_q & fen_q;

endmodule

// File: rtl/frz_mode_fsm.sv
module frz_mode_fsm
  import frz_pkg::*;
#(
  parameter logic RST_FROZEN = 1'b1
) (
  input  logic clk,
  input  logic rst_n,
  input  logic frz_req,
  input  logic eng_idle,
  input  logic lp_mode,
  output logic presc_stop,
  output logic frz_ack
);

  localparam frz_state_e RST_STATE = RST_FROZEN ? FS_FROZEN : FS_RUN;

  frz_state_e state_q, state_d;

  always_comb begin
    state_d = state_q;
    unique case (state_q)
      FS_RUN:    if (frz_req && eng_idle && !lp_mode) state_d = FS_STOP;
      FS_STOP:   state_d = frz_req ? FS_FROZEN : FS_RUN;
      FS_FROZEN: if (!frz_req) state_d = FS_RUN;
      default:   state_d = FS_RUN;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) state_q <= RST_STATE;
    else        state_q <= state_d;
  end

  assign presc_stop = (state_q == FS_STOP) || (state_q == FS_FROZEN);
  assign frz_ack    = (state_q == FS_FROZEN);

endmodule

// File: rtl/frz_dis_track.sv
module frz_dis_track (
  input  logic clk,
  input  logic rst_n,
  input  logic mdis,
  input  logic eng_idle,
  output logic dis_q
);

  // enter only once the bus activity has drained, leave as soon as released
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) dis_q <= 1'b0;
    else        dis_q <= mdis & (dis_q | eng_idle);
  end

endmodule

// File: rtl/frz_err_cnt_reg.sv
module frz_err_cnt_reg #(
  parameter int W = 16
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         frozen,
  input  logic         cpu_wr,
  input  logic [W-1:0] cpu_data,
  input  logic         eng_upd,
  input  logic [W-1:0] eng_data,
  output logic [W-1:0] value
);

  logic cpu_ok;
  assign cpu_ok = cpu_wr & frozen;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       value <= '0;
    else if (cpu_ok)  value <= cpu_data;
    else if (eng_upd) value <= eng_data;
  end

endmodule

// File: rtl/can_frz_seq.sv
module can_frz_seq #(
  parameter int   ECR_W    = 16,
  parameter logic HALT_RST = 1'b1,
  parameter logic FEN_RST  = 1'b1
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             ctl_wr,
  input  logic             ctl_halt,
  input  logic             ctl_frz_en,
  input  logic             mdis,
  input  logic             lp_mode,
  input  logic             tx_busy,
  input  logic             rx_busy,
  input  logic             ecr_wr,
  input  logic [ECR_W-1:0] ecr_wdata,
  input  logic             eng_upd,
  input  logic [ECR_W-1:0] eng_data,
  output logic             presc_stop,
  output logic             frz_ack,
  output logic             not_rdy,
  output logic             xfer_start_ok,
  output logic [ECR_W-1:0] ecr_value
);

  localparam logic RST_FROZEN = HALT_RST & FEN_RST;

  logic halt_q, fen_q, frz_req, eng_idle, dis_q;

  assign eng_idle = ~tx_busy & ~rx_busy;

  frz_ctl_bits #(.HALT_RST(HALT_RST), .FEN_RST(FEN_RST)) u_ctl (
    .clk(clk), .rst_n(rst_n), .wr(ctl_wr), .halt_d(ctl_halt),
    .fen_d(ctl_frz_en), .halt_q(halt_q), .fen_q(fen_q), .frz_req(frz_req)
  );

  frz_mode_fsm #(.RST_FROZEN(RST_FROZEN)) u_fsm (
    .clk(clk), .rst_n(rst_n), .frz_req(frz_req), .eng_idle(eng_idle),
    .lp_mode(lp_mode), .presc_stop(presc_stop), .frz_ack(frz_ack)
  );

  frz_dis_track u_dis (
    .clk(clk), .rst_n(rst_n), .mdis(mdis), .eng_idle(eng_idle), .dis_q(dis_q)
  );

  frz_err_cnt_reg #(.W(ECR_W)) u_ecr (
    .clk(clk), .rst_n(rst_n), .frozen(frz_ack), .cpu_wr(ecr_wr),
    .cpu_data(ecr_wdata), .eng_upd(eng_upd), .eng_data(eng_data),
    .value(ecr_value)
  );

  assign not_rdy       = frz_ack | dis_q;
  assign xfer_start_ok = ~presc_stop & ~halt_q & ~dis_q & ~lp_mode;

endmodule

// File: rtl/frz_seq_chk.sv
module frz_seq_chk #(
  parameter int ECR_W = 16
) (
  input logic             clk,
  input logic             rst_n,
  input logic             lp_mode,
  input logic             tx_busy,
  input logic             rx_busy,
  input logic             ecr_wr,
  input logic             eng_upd,
  input logic             presc_stop,
  input logic             frz_ack,
  input logic             not_rdy,
  input logic             xfer_start_ok,
  input logic [ECR_W-1:0] ecr_value
);

  a_r3_ack_after_stop: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(frz_ack) |-> $past(presc_stop));

  a_r4_stop_needs_idle: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(presc_stop) |-> $past(!tx_busy && !rx_busy));

  a_r5_stop_not_in_lp: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(presc_stop) |-> $past(!lp_mode));

  a_r6_ack_falls_with_stop: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(frz_ack) |-> !presc_stop);

  a_r7_frozen_not_ready: assert property (@(posedge clk) disable iff (!rst_n)
    frz_ack |-> not_rdy);

  a_r8_no_start_when_stopped: assert property (@(posedge clk) disable iff (!rst_n)
    xfer_start_ok |-> (!presc_stop && !not_rdy && !lp_mode));

  a_r9_cpu_write_blocked: assert property (@(posedge clk) disable iff (!rst_n)
    (ecr_wr && !frz_ack && !eng_upd) |=> $stable(ecr_value));

endmodule

bind can_frz_seq frz_seq_chk #(.ECR_W(ECR_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .lp_mode(lp_mode), .tx_busy(tx_busy),
  .rx_busy(rx_busy), .ecr_wr(ecr_wr), .eng_upd(eng_upd),
  .presc_stop(presc_stop), .frz_ack(frz_ack), .not_rdy(not_rdy),
  .xfer_start_ok(xfer_start_ok), .ecr_value(ecr_value)
);

// File: tb/tb_can_frz_seq.sv
`timescale 1ns/1ps
module tb_can_frz_seq;

  localparam int W = 16;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic ctl_wr = 0, ctl_halt = 0, ctl_frz_en = 0;
  logic mdis = 0, lp_mode = 0, tx_busy = 0, rx_busy = 0;
  logic ecr_wr = 0, eng_upd = 0;
  logic [W-1:0] ecr_wdata = '0, eng_data = '0;
  logic presc_stop, frz_ack, not_rdy, xfer_start_ok;
  logic [W-1:0] ecr_value;

  int checks = 0;
  int failures = 0;
  bit done = 0;

  always #2.5 clk = ~clk;

  can_frz_seq #(.ECR_W(W)) dut (
    .clk(clk), .rst_n(rst_n), .ctl_wr(ctl_wr), .ctl_halt(ctl_halt),
    .ctl_frz_en(ctl_frz_en), .mdis(mdis), .lp_mode(lp_mode),
    .tx_busy(tx_busy), .rx_busy(rx_busy), .ecr_wr(ecr_wr),
    .ecr_wdata(ecr_wdata), .eng_upd(eng_upd), .eng_data(eng_data),
    .presc_stop(presc_stop), .frz_ack(frz_ack), .not_rdy(not_rdy),
    .xfer_start_ok(xfer_start_ok), .ecr_value(ecr_value)
  );

  task automatic chk(input string req, input string what,
                     input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  task automatic tick(input int n);
    for (int i = 0; i < n; i++) @(negedge clk);
  endtask

  task automatic write_ctl(input logic h, input logic f);
    ctl_halt = h; ctl_frz_en = f; ctl_wr = 1'b1;
    tick(1);
    ctl_wr = 1'b0;
  endtask

  task automatic cpu_ecr(input logic [W-1:0] d);
    ecr_wdata = d; ecr_wr = 1'b1;
    tick(1);
    ecr_wr = 1'b0;
  endtask

  task automatic t_reset();
    chk("R1", "presc_stop", presc_stop, 1);
    chk("R1", "frz_ack", frz_ack, 1);
    chk("R1", "not_rdy", not_rdy, 1);
    chk("R1", "xfer_start_ok", xfer_start_ok, 0);
    chk("R1", "ecr_value", ecr_value, 0);
  endtask

  task automatic t_ecr_frozen();
    cpu_ecr(16'hA55A);
    chk("R9", "ecr accepted while frozen", ecr_value, 16'hA55A);
  endtask

  task automatic t_exit();
    write_ctl(1'b0, 1'b1);
    chk("R6", "ack held until next edge", frz_ack, 1);
    tick(1);
    chk("R6", "frz_ack cleared", frz_ack, 0);
    chk("R6", "presc_stop cleared", presc_stop, 0);
    chk("R7", "not_rdy after exit", not_rdy, 0);
    chk("R8", "start allowed", xfer_start_ok, 1);
  endtask

  task automatic t_ecr_running();
    cpu_ecr(16'h3C3C);
    chk("R9", "cpu write ignored while running", ecr_value, 16'hA55A);
    eng_data = 16'h0111; eng_upd = 1'b1;
    tick(1);
    eng_upd = 1'b0;
    chk("R10", "engine update", ecr_value, 16'h0111);
  endtask

  task automatic t_busy();
    tx_busy = 1'b1;
    write_ctl(1'b1, 1'b1);
    chk("R8", "no start with halt set", xfer_start_ok, 0);
    tick(3);
    chk("R4", "no stop while tx busy", presc_stop, 0);
    chk("R4", "no ack while tx busy", frz_ack, 0);
    rx_busy = 1'b1; tx_busy = 1'b0;
    tick(2);
    chk("R4", "no stop while rx busy", presc_stop, 0);
    rx_busy = 1'b0;
    tick(1);
    chk("R3", "stop after idle", presc_stop, 1);
    chk("R3", "ack not yet", frz_ack, 0);
    tick(1);
    chk("R3", "ack one edge later", frz_ack, 1);
    write_ctl(1'b0, 1'b1);
    tick(1);
  endtask

  task automatic t_lp();
    lp_mode = 1'b1;
    write_ctl(1'b1, 1'b1);
    tick(4);
    chk("R5", "no stop in low power", presc_stop, 0);
    chk("R5", "no ack in low power", frz_ack, 0);
    lp_mode = 1'b0;
    tick(1);
    chk("R5", "stop after low power", presc_stop, 1);
    tick(1);
    chk("R5", "ack after low power", frz_ack, 1);
    write_ctl(1'b0, 1'b1);
    tick(1);
  endtask

  task automatic t_fen_off();
    write_ctl(1'b1, 1'b0);
    tick(3);
    chk("R2", "no stop without enable", presc_stop, 0);
    chk("R2", "no ack without enable", frz_ack, 0);
    chk("R2", "not_rdy low", not_rdy, 0);
    chk("R8", "halt blocks start", xfer_start_ok, 0);
    write_ctl(1'b0, 1'b1);
    chk("R8", "start after halt cleared", xfer_start_ok, 1);
  endtask

  task automatic t_withdraw();
    tx_busy = 1'b1;
    write_ctl(1'b1, 1'b1);
    tick(2);
    write_ctl(1'b0, 1'b1);
    tx_busy = 1'b0;
    tick(3);
    chk("R11", "no ack after withdraw", frz_ack, 0);
    chk("R11", "no stop after withdraw", presc_stop, 0);
    chk("R11", "start allowed again", xfer_start_ok, 1);
  endtask

  task automatic t_disable();
    tx_busy = 1'b1; mdis = 1'b1;
    tick(2);
    chk("R7", "disable waits for idle", not_rdy, 0);
    tx_busy = 1'b0;
    tick(1);
    chk("R7", "disabled not ready", not_rdy, 1);
    chk("R8", "no start when disabled", xfer_start_ok, 0);
    chk("R7", "no ack when disabled", frz_ack, 0);
    mdis = 1'b0;
    tick(1);
    chk("R7", "ready after enable", not_rdy, 0);
    chk("R8", "start after enable", xfer_start_ok, 1);
  endtask

  initial begin
    tick(3);
    rst_n = 1'b1;
    tick(1);
    t_reset();
    t_ecr_frozen();
    t_exit();
    t_ecr_running();
    t_busy();
    t_lp();
    t_fen_off();
    t_withdraw();
    t_disable();
    done = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      checks++;
      failures++;
      $display("FAIL watchdog actual=timeout expected=finish");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

endmodule